// File: doc/BRIEF.md
# Line Sensor Timing Generator

This block generates the drive waveforms that a linear image sensor needs to read out one line. A pixel shift clock idles high. A transfer-gate pulse moves the exposed charge into the shift register once per line. A reset strobe can optionally be driven from outside the sensor. Every duration is counted in cycles of the faster system clock and is set through configuration inputs. The configuration and the mode are captured when a line is launched.

Downstream sampling logic uses three outputs to tag its samples. `busy_o` frames the line. `line_start_o` marks the first pixel period. `pix_idx_o` gives the zero-based number of the current pixel period. Two mode inputs select one of three operating modes:

- internal reset without sample-and-hold
- internal reset with sample-and-hold
- external reset

The block drives the sensor's mode-select level and its shared reset/hold pin to match the selected mode. A configuration that breaks a timing minimum raises a combinational error flag, and the block refuses to launch a line while that flag is high.

Top module: `lsg_top`

## Requirements
- R1: After reset, `busy_o`=0, `pclk_o`=1, `gate_o`=0, `pix_idx_o`=0, `line_start_o`=0, `rsel_o`=0 and `rs_sh_o`=0.
- R2: A `start_i` pulse with a legal configuration produces the following sequence. `busy_o` rises the next cycle. `pclk_o` then stays high with `gate_o` low for `lead_len_i` cycles. `gate_o` is then high for exactly `gate_len_i` cycles. `pclk_o` then stays high for `trail_len_i` more cycles before its first fall.
- R3: `gate_o` is high only while `pclk_o` is high.
- R4: Each line contains exactly NPIX pixel periods. Each period is `half_len_i` cycles low followed by `half_len_i` cycles high. `busy_o` falls right after the high half of the last period.
- R5: `pix_idx_o` equals the zero-based pixel number during the low half of each period. `line_start_o` is a one-cycle pulse in the first low cycle of pixel 0 and occurs nowhere else.
- R6: External mode (`ext_rst_i`=1, `hold_en_i`=0) works as follows. `rsel_o`=1. `rs_sh_o` is low during the first `rst_len_i` cycles of each high half and high at all other times, which gives NPIX*`rst_len_i` low cycles per line.
- R7: In the internal modes (`ext_rst_i`=0), `rsel_o`=0 and `rs_sh_o` holds the level of `hold_en_i` for the whole line.
- R8: `cfg_err_o`=1 under any of these conditions: half<MIN_HALF; gate<MIN_GATE; lead<MIN_LEAD; trail<MIN_TRAIL; in external mode, rst<MIN_RST or rst>half; both mode inputs high. A `start_i` while `cfg_err_o`=1 in idle is ignored.
- R9: A `start_i` that arrives during a line is held. The next line's lead phase follows directly after the last high half, with `busy_o` staying high, so `pclk_o` is high for `half_len_i`+`lead_len_i` cycles before the gate.
- R10: Configuration and mode are sampled at launch. Changing them during a line has no effect on that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Line request pulse |
| half_len_i | input | CFG_W | Shift-clock half period, cycles |
| gate_len_i | input | CFG_W | Transfer-gate high time, cycles |
| lead_len_i | input | CFG_W | Clock hold before gate, cycles |
| trail_len_i | input | CFG_W | Clock hold after gate, cycles |
| rst_len_i | input | CFG_W | External reset low time, cycles |
| ext_rst_i | input | 1 | Select external reset drive |
| hold_en_i | input | 1 | Sample-and-hold enable (internal mode) |
| busy_o | output | 1 | Line in progress |
| line_start_o | output | 1 | First cycle of pixel 0 |
| pix_idx_o | output | PIX_W | Current pixel number |
| cfg_err_o | output | 1 | Configuration violates a minimum |
| pclk_o | output | 1 | Pixel shift clock, idle high |
| gate_o | output | 1 | Transfer-gate pulse |
| rsel_o | output | 1 | Sensor reset-source select level |
| rs_sh_o | output | 1 | Reset strobe or hold-enable level |

## Verification
On every cycle, the assertions check several relations:
- the gate is never high while the shift clock is low
- the shift clock never goes low outside a line
- the reset strobe falls only in the high half of a pixel period in external mode
- the line-start marker coincides with pixel 0 in a low half
- a request during a line is captured
- the captured configuration stays fixed through the gate phase

Only the bench scenarios can show the exact segment lengths, the pixel count per line, the seamless back-to-back start and the refusal to launch under a bad configuration. They do this by comparing each measured line against its expected record.

// File: rtl/lsg_pkg.sv
package lsg_pkg;
    localparam int CFG_W = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_GATE,
        ST_TRAIL,
        ST_SHIFT
    } seq_state_t;

    typedef struct packed {
        logic [CFG_W-1:0] half_len;
        logic [CFG_W-1:0] gate_len;
        logic [CFG_W-1:0] lead_len;
        logic [CFG_W-1:0] trail_len;
        logic [CFG_W-1:0] rst_len;
    } lsg_timing_t;

    typedef struct packed {
        logic ext_rst;
        logic hold_en;
    } lsg_mode_t;

    function automatic logic seg_last(input logic [CFG_W-1:0] tmr,
                                      input logic [CFG_W-1:0] len);
        return (tmr + 1'b1) == len;
    endfunction
endpackage

// File: rtl/lsg_cfg_chk.sv
module lsg_cfg_chk
    import lsg_pkg::*;
#(
    parameter int MIN_HALF  = 4,
    parameter int MIN_GATE  = 120,
    parameter int MIN_LEAD  = 20,
    parameter int MIN_TRAIL = 120,
    parameter int MIN_RST   = 3
) (
    input  lsg_timing_t timing_i,
    input  lsg_mode_t   mode_i,
    output logic        err_o
);
    logic short_any;
    logic rst_bad;

    always_comb begin
        short_any = (timing_i.half_len  < CFG_W'(MIN_HALF))
                  | (timing_i.gate_len  < CFG_W'(MIN_GATE))
                  | (timing_i.lead_len  < CFG_W'(MIN_LEAD))
                  | (timing_i.trail_len < CFG_W'(MIN_TRAIL));
        rst_bad   = mode_i.ext_rst &
                    ((timing_i.rst_len < CFG_W'(MIN_RST)) |
                     (timing_i.rst_len > timing_i.half_len));
        err_o     = short_any | rst_bad | (mode_i.ext_rst & mode_i.hold_en);
    end
endmodule

// File: rtl/lsg_seq.sv
module lsg_seq
    import lsg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic        cfg_err_i,
    input  lsg_timing_t timing_i,
    input  lsg_mode_t   mode_i,
    input  logic        line_done_i,
    output seq_state_t  state_o,
    output lsg_timing_t timing_o,
    output lsg_mode_t   mode_o
);
    seq_state_t       state_q, state_n;
    logic [CFG_W-1:0] tmr_q, tmr_n;
    logic             pend_q, pend_n;
    logic             launch;
    lsg_timing_t      timing_q;
    lsg_mode_t        mode_q;

    always_comb begin
        state_n = state_q;
        tmr_n   = tmr_q + 1'b1;
        pend_n  = pend_q | (start_i & (state_q != ST_IDLE));
        launch  = 1'b0;
        case (state_q)
            ST_IDLE: begin
                tmr_n = '0;
                if ((start_i | pend_q) & ~cfg_err_i) launch = 1'b1;
            end
            ST_LEAD: if (seg_last(tmr_q, timing_q.lead_len)) begin
                state_n = ST_GATE;
                tmr_n   = '0;
            end
            ST_GATE: if (seg_last(tmr_q, timing_q.gate_len)) begin
                state_n = ST_TRAIL;
                tmr_n   = '0;
            end
            ST_TRAIL: if (seg_last(tmr_q, timing_q.trail_len)) begin
                state_n = ST_SHIFT;
                tmr_n   = '0;
            end
            ST_SHIFT: begin
                tmr_n = '0;
                if (line_done_i) begin
                    if (pend_q & ~cfg_err_i) launch = 1'b1;
                    else state_n = ST_IDLE;
                end
            end
            default: state_n = ST_IDLE;
        endcase
        if (launch) begin
            state_n = ST_LEAD;
            tmr_n   = '0;
            pend_n  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            tmr_q    <= '0;
            pend_q   <= 1'b0;
            timing_q <= '0;
            mode_q   <= '0;
        end else begin
            state_q <= state_n;
            tmr_q   <= tmr_n;
            pend_q  <= pend_n;
            if (launch) begin
                timing_q <= timing_i;
                mode_q   <= mode_i;
            end
        end
    end

    assign state_o  = state_q;
    assign timing_o = timing_q;
    assign mode_o   = mode_q;

    // a request during a line is never dropped
    assert_pend_capture_R9: assert property (@(posedge clk) disable iff (rst)
        (start_i && state_q != ST_IDLE && !pend_q) |=> pend_q);

    assert_blocked_start_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && cfg_err_i && !pend_q) |=> state_q == ST_IDLE);

    assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_GATE) |=> $stable(timing_q) && $stable(mode_q));
endmodule

// File: rtl/lsg_pix.sv
module lsg_pix
    import lsg_pkg::*;
#(
    parameter int NPIX  = 8042,
    parameter int PIX_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic [CFG_W-1:0] half_len_i,
    input  logic [CFG_W-1:0] rst_len_i,
    input  logic             ext_i,
    output logic             pclk_o,
    output logic             rs_n_o,
    output logic [PIX_W-1:0] idx_o,
    output logic             first_o,
    output logic             done_o
);
    logic [CFG_W-1:0] hcnt_q;
    logic             hi_q;
    logic [PIX_W-1:0] idx_q;
    logic             half_end;

    assign half_end = seg_last(hcnt_q, half_len_i);
    assign done_o   = run_i & hi_q & half_end & (idx_q == PIX_W'(NPIX - 1));

    always_ff @(posedge clk) begin
        if (rst || !run_i || done_o) begin
            hcnt_q <= '0;
            hi_q   <= 1'b0;
            idx_q  <= '0;
        end else if (half_end) begin
            hcnt_q <= '0;
            hi_q   <= ~hi_q;
            if (hi_q) idx_q <= idx_q + 1'b1;
        end else begin
            hcnt_q <= hcnt_q + 1'b1;
        end
    end

    assign pclk_o  = ~(run_i & ~hi_q);
    assign rs_n_o  = ~(ext_i & run_i & hi_q & (hcnt_q < rst_len_i));
    assign idx_o   = idx_q;
    assign first_o = run_i & ~hi_q & (hcnt_q == '0) & (idx_q == '0);

    assert_idx_range_R4: assert property (@(posedge clk) disable iff (rst)
        run_i |-> idx_q < PIX_W'(NPIX));
endmodule

// File: rtl/lsg_top.sv
module lsg_top
    import lsg_pkg::*;
#(
    parameter int NPIX      = 8042,
    parameter int MIN_HALF  = 4,
    parameter int MIN_GATE  = 120,
    parameter int MIN_LEAD  = 20,
    parameter int MIN_TRAIL = 120,
    parameter int MIN_RST   = 3,
    localparam int PIX_W    = $clog2(NPIX + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [CFG_W-1:0] half_len_i,
    input  logic [CFG_W-1:0] gate_len_i,
    input  logic [CFG_W-1:0] lead_len_i,
    input  logic [CFG_W-1:0] trail_len_i,
    input  logic [CFG_W-1:0] rst_len_i,
    input  logic             ext_rst_i,
    input  logic             hold_en_i,
    output logic             busy_o,
    output logic             line_start_o,
    output logic [PIX_W-1:0] pix_idx_o,
    output logic             cfg_err_o,
    output logic             pclk_o,
    output logic             gate_o,
    output logic             rsel_o,
    output logic             rs_sh_o
);
    lsg_timing_t timing_in, timing_q;
    lsg_mode_t   mode_in, mode_q;
    seq_state_t  state;
    logic        line_done;
    logic        rs_n;

    assign timing_in = '{half_len: half_len_i, gate_len: gate_len_i,
                         lead_len: lead_len_i, trail_len: trail_len_i,
                         rst_len: rst_len_i};
    assign mode_in   = '{ext_rst: ext_rst_i, hold_en: hold_en_i};

    lsg_cfg_chk #(
        .MIN_HALF(MIN_HALF), .MIN_GATE(MIN_GATE), .MIN_LEAD(MIN_LEAD),
        .MIN_TRAIL(MIN_TRAIL), .MIN_RST(MIN_RST)
    ) chk_i (
        .timing_i(timing_in),
        .mode_i  (mode_in),
        .err_o   (cfg_err_o)
    );

    lsg_seq seq_i (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .cfg_err_i  (cfg_err_o),
        .timing_i   (timing_in),
        .mode_i     (mode_in),
        .line_done_i(line_done),
        .state_o    (state),
        .timing_o   (timing_q),
        .mode_o     (mode_q)
    );

    lsg_pix #(.NPIX(NPIX), .PIX_W(PIX_W)) pix_i (
        .clk       (clk),
        .rst       (rst),
        .run_i     (state == ST_SHIFT),
        .half_len_i(timing_q.half_len),
        .rst_len_i (timing_q.rst_len),
        .ext_i     (mode_q.ext_rst),
        .pclk_o    (pclk_o),
        .rs_n_o    (rs_n),
        .idx_o     (pix_idx_o),
        .first_o   (line_start_o),
        .done_o    (line_done)
    );

    assign busy_o  = (state != ST_IDLE);
    assign gate_o  = (state == ST_GATE);
    assign rsel_o  = mode_q.ext_rst;
    assign rs_sh_o = mode_q.ext_rst ? rs_n : mode_q.hold_en;

    assert_gate_clk_idle_R3: assert property (@(posedge clk) disable iff (rst)
        gate_o |-> pclk_o);

    assert_clk_in_line_R4: assert property (@(posedge clk) disable iff (rst)
        !pclk_o |-> busy_o);

    assert_line_mark_R5: assert property (@(posedge clk) disable iff (rst)
        line_start_o |-> (!pclk_o && pix_idx_o == '0));

    assert_rs_high_half_R6: assert property (@(posedge clk) disable iff (rst)
        !rs_sh_o && rsel_o |-> (pclk_o && busy_o));

    assert_hold_level_R7: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !rsel_o && !pclk_o) |-> rs_sh_o == $past(rs_sh_o));
endmodule

// File: tb/lsg_top_tb_top.sv
module lsg_top_tb_top;
    import lsg_pkg::*;

    localparam int NP = 6;
    localparam int PW = $clog2(NP + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [CFG_W-1:0] half_l, gate_l, lead_l, trail_l, rst_l;
    logic ext_m, hold_m;
    logic busy, ls, cfg_err, pclk, gate, rsel, rs_sh;
    logic [PW-1:0] pix_idx;

    always #10 clk = ~clk;

    lsg_top #(.NPIX(NP), .MIN_HALF(2), .MIN_GATE(3), .MIN_LEAD(2),
              .MIN_TRAIL(3), .MIN_RST(1)) dut_i (
        .clk(clk), .rst(rst), .start_i(start),
        .half_len_i(half_l), .gate_len_i(gate_l), .lead_len_i(lead_l),
        .trail_len_i(trail_l), .rst_len_i(rst_l),
        .ext_rst_i(ext_m), .hold_en_i(hold_m),
        .busy_o(busy), .line_start_o(ls), .pix_idx_o(pix_idx),
        .cfg_err_o(cfg_err), .pclk_o(pclk), .gate_o(gate),
        .rsel_o(rsel), .rs_sh_o(rs_sh)
    );

    typedef struct {
        int pre; int gat; int post; int nfall; int bad_fmt; int bad_mode;
        int rslow; int ls; int half; int rw; bit ext; bit sh;
    } line_rec_t;

    line_rec_t exp_q[$];
    line_rec_t cur;
    int total = 0;
    int bad = 0;
    bit finished = 0;
    bit open = 0;
    int gap = 0;
    int low = 0;
    logic prev_p = 1'b1, prev_g = 1'b0, prev_b = 1'b0;

    task automatic chk(bit ok, string tag, int act, int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic close_line();
        line_rec_t e;
        if (exp_q.size() == 0) begin
            chk(0, "R4 unexpected line", 1, 0);
        end else begin
            e = exp_q.pop_front();
            chk(cur.pre == e.pre, "R2 R9 lead hold", cur.pre, e.pre);
            chk(cur.gat == e.gat, "R2 gate width", cur.gat, e.gat);
            chk(cur.post == e.post, "R2 trail hold", cur.post, e.post);
            chk(cur.nfall == e.nfall, "R4 pixel count", cur.nfall, e.nfall);
            chk(cur.bad_fmt == 0, "R4 R5 period/index errors", cur.bad_fmt, 0);
            chk(cur.bad_mode == 0, "R6 R7 mode pin errors", cur.bad_mode, 0);
            chk(cur.rslow == e.rslow, "R6 reset low cycles", cur.rslow, e.rslow);
            chk(cur.ls == 1, "R5 line start count", cur.ls, 1);
        end
        open = 0;
    endtask

    // monitor: measures each line and compares it with the queue head
    always @(negedge clk) begin
        if (rst) begin
            open = 0; gap = 0; low = 0;
            prev_p = 1'b1; prev_g = 1'b0; prev_b = 1'b0;
        end else begin
            bit fall;
            fall = prev_p && !pclk;
            if (prev_b && !busy && open) close_line();
            if (!busy) gap = 0;
            else if (gate) begin
                if (!prev_g) begin
                    if (open) close_line();
                    open = 1;
                    cur = '{default: 0};
                    cur.pre = gap;
                end
                gap = 0;
                cur.gat++;
            end else if (pclk) begin
                gap = prev_p ? gap + 1 : 1;
            end
            if (open && busy && exp_q.size() > 0) begin
                if (fall) begin
                    if (cur.nfall == 0) begin
                        cur.post = gap;
                        if (!ls) cur.bad_fmt++;
                    end else if (gap != exp_q[0].half) cur.bad_fmt++;
                    if (int'(pix_idx) != cur.nfall) cur.bad_fmt++;
                    cur.nfall++;
                    low = 1;
                end else if (!pclk) begin
                    low++;
                end else if (!prev_p && low != exp_q[0].half) begin
                    cur.bad_fmt++;
                end
                if (ls) begin
                    cur.ls++;
                    if (!(fall && cur.nfall == 1)) cur.bad_fmt++;
                end
                if (rsel != exp_q[0].ext) cur.bad_mode++;
                if (!exp_q[0].ext && rs_sh != exp_q[0].sh) cur.bad_mode++;
                if (exp_q[0].ext && !rs_sh) begin
                    cur.rslow++;
                    if (!pclk || gap > exp_q[0].rw) cur.bad_mode++;
                end
            end
            prev_p = pclk; prev_g = gate; prev_b = busy;
        end
    end

    task automatic set_cfg(int h, int g, int p, int t, int r, bit e, bit s);
        half_l = CFG_W'(h); gate_l = CFG_W'(g); lead_l = CFG_W'(p);
        trail_l = CFG_W'(t); rst_l = CFG_W'(r); ext_m = e; hold_m = s;
    endtask

    task automatic push_exp(bit b2b);
        line_rec_t e;
        e = '{default: 0};
        e.half = int'(half_l); e.rw = int'(rst_l); e.ext = ext_m; e.sh = hold_m;
        e.pre = int'(lead_l) + (b2b ? int'(half_l) : 0);
        e.gat = int'(gate_l); e.post = int'(trail_l); e.nfall = NP;
        e.rslow = ext_m ? NP * int'(rst_l) : 0; e.ls = 1;
        exp_q.push_back(e);
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (busy);
        repeat (3) @(negedge clk);
    endtask

    task automatic run_line();
        push_exp(0);
        pulse_start();
        wait_idle();
    endtask

    initial begin
        set_cfg(2, 4, 3, 4, 1, 0, 0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 0, "R1 busy", busy, 0);
        chk(pclk == 1, "R1 pclk", pclk, 1);
        chk(gate == 0, "R1 gate", gate, 0);
        chk(pix_idx == 0, "R1 pix_idx", pix_idx, 0);
        chk(ls == 0, "R1 line_start", ls, 0);
        chk(rsel == 0 && rs_sh == 0, "R1 mode pins", {rsel, rs_sh}, 0);

        // R2 R4 R5 R7: internal, no hold, minimum half period
        run_line();
        // R7: internal with hold
        set_cfg(3, 3, 2, 3, 1, 0, 1);
        run_line();
        // R6: external, reset width 2 of half 4
        set_cfg(4, 5, 2, 3, 2, 1, 0);
        run_line();
        // R6 boundary: reset width equals half
        set_cfg(3, 3, 4, 3, 3, 1, 0);
        chk(cfg_err == 0, "R8 legal boundary cfg", cfg_err, 0);
        run_line();

        // R9: request during a line runs back to back
        set_cfg(2, 3, 2, 3, 1, 0, 0);
        push_exp(0);
        pulse_start();
        repeat (4) @(negedge clk);
        push_exp(1);
        pulse_start();
        wait_idle();

        // R10: change config mid-line
        set_cfg(3, 4, 3, 5, 1, 0, 1);
        push_exp(0);
        pulse_start();
        repeat (3) @(negedge clk);
        set_cfg(2, 6, 2, 3, 1, 0, 0);
        wait_idle();
        run_line();

        // R8: illegal configurations
        set_cfg(2, 2, 2, 3, 1, 0, 0);
        @(negedge clk);
        chk(cfg_err == 1, "R8 gate below minimum", cfg_err, 1);
        pulse_start();
        repeat (8) @(negedge clk);
        chk(busy == 0, "R8 start ignored", busy, 0);
        chk(pclk == 1 && gate == 0, "R8 outputs idle", {pclk, gate}, 2);
        set_cfg(1, 3, 2, 3, 1, 0, 0);
        @(negedge clk);
        chk(cfg_err == 1, "R8 half below minimum", cfg_err, 1);
        set_cfg(2, 3, 2, 3, 3, 1, 0);
        @(negedge clk);
        chk(cfg_err == 1, "R8 reset longer than half", cfg_err, 1);
        set_cfg(2, 3, 2, 3, 1, 1, 1);
        @(negedge clk);
        chk(cfg_err == 1, "R8 external with hold", cfg_err, 1);
        set_cfg(2, 3, 1, 3, 1, 0, 0);
        @(negedge clk);
        chk(cfg_err == 1, "R8 lead below minimum", cfg_err, 1);
        set_cfg(2, 3, 2, 3, 0, 0, 0);
        @(negedge clk);
        chk(cfg_err == 0, "R8 reset width unused in internal mode", cfg_err, 0);

        chk(exp_q.size() == 0, "R4 lines outstanding", exp_q.size(), 0);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R4 watchdog actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule